// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counter Timer

This block is a timer unit that sits on a simple register bus. It has several independent 32-bit down-counting channels, and each channel drives its own interrupt line. One 8-bit run register is shared by all channels and holds one run bit per channel. Each channel has three registers: a reload value, the live count, and a control word. The control word selects a prescaled count clock, enables the interrupt and holds a sticky underflow flag.

Software loads the reload and count registers, then sets the channel's run bit. On every prescaled tick the channel decrements its count. A tick that finds the count at zero reloads the count from the reload register and sets the flag. Writing the same value to both registers gives a periodic tick. Loading the reload register with all ones makes the channel behave as a one-shot with the longest possible rearm time. Reads are combinational. Writes take effect at the clock edge on which `sel` and `wr` are both high.

Top module: `mc_timer`

## Requirements
- R1: After reset the run register reads 0, every reload and count register reads 0xFFFFFFFF, every control word reads 0 and every interrupt output is low.
- R2: The run register is at byte address START_OFS (default 4). Only its low NUM_CH bits are stored, and the upper bits read as zero. Channel n's registers are at CH_BASE + 12n (default CH_BASE 8): reload at +0, count at +4, control at +8. A write to one address changes no other register.
- R3: A channel decrements only while its run bit (bit n of the run register) is 1. A stopped channel holds its count, and the run bits of the channels act independently of each other.
- R4: Control bits [2:0] select the tick period: codes 0, 1, 2, 3 and 4 give 4, 16, 64, 256 and 1024 clocks, and codes 5 to 7 give 1024. The shared prescaler runs only while some run bit is set. When no channel was running before, a channel's first tick lands on the D-th clock edge after the edge that wrote its run bit.
- R5: A tick that finds the count at zero loads the reload value and sets the flag (control bit 8) on the same edge.
- R6: The value 0xFFFFFFFF is stored in full by the reload and count registers and is reloaded on underflow.
- R7: Writing the control word with bit 8 at 0 clears the flag. Writing it with bit 8 at 1 leaves the flag unchanged and never sets it.
- R8: Interrupt n is a registered, active-high level equal to flag AND enable (control bit 5). It changes on the same edge as the flag or the enable bit.
- R9: A count write takes effect on its edge even while the channel runs, and it wins over a decrement or reload due on that edge.
- R10: The control word reads back bits [2:0], bit 5 and bit 8. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sel | input | 1 | Bus access select |
| wr | input | 1 | Write strobe when sel is high; read otherwise |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for the addressed register |
| irq | output | NUM_CH | Per-channel interrupt level |

## Verification
The assertions that compare a reload against the previous reload value take for granted that software never rewrites a channel's reload register on the same edge as that channel's underflow. The stimulus meets this by loading the reload values only while the channels are stopped. The checks on held counts assume that count writes come only through the bus. The bench times every run-bit write against a prescaler that starts from idle: it stops all channels between tests, so each test knows on which edge its ticks fall.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int MAX_CH  = 8;   // width of the shared run register
  localparam int NUM_DIV = 5;   // prescaler taps: /4 /16 /64 /256 /1024
  localparam int DATA_W  = 32;
  localparam int CTRL_W  = 16;
  localparam int PRE_W   = 2 * NUM_DIV;

  typedef struct packed {
    logic [MAX_CH-1:0]  wrConst;
    logic [MAX_CH-1:0]  wrCount;
    logic [MAX_CH-1:0]  wrCtrl;
    logic [MAX_CH-1:0]  run;
    logic [NUM_DIV-1:0] tick;
    logic [DATA_W-1:0]  wdata;
  } tmr_strb_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int ADDR_W    = 8,
  parameter int START_OFS = 4,
  parameter int CH_BASE   = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sel,
  input  logic                     wr,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_CH*DATA_W-1:0] constVals,
  input  logic [NUM_CH*DATA_W-1:0] cntVals,
  input  logic [NUM_CH*CTRL_W-1:0] ctrlVals,
  output tmr_strb_t                strb,
  output logic [DATA_W-1:0]        rdata
);
  localparam int CH_STRIDE = 12;
  localparam logic [MAX_CH-1:0] CH_MASK = MAX_CH'((1 << NUM_CH) - 1);

  logic [MAX_CH-1:0] runReg;
  logic [PRE_W-1:0]  preCnt;
  logic [MAX_CH-1:0] hitConst, hitCount, hitCtrl;
  logic              hitRun, anyRun;

  assign hitRun = sel && (addr == ADDR_W'(START_OFS));
  assign anyRun = |runReg;

  for (genvar c = 0; c < MAX_CH; c++) begin : g_dec
    if (c < NUM_CH) begin : g_on
      assign hitConst[c] = sel && (addr == ADDR_W'(CH_BASE + c*CH_STRIDE));
      assign hitCount[c] = sel && (addr == ADDR_W'(CH_BASE + c*CH_STRIDE + 4));
      assign hitCtrl[c]  = sel && (addr == ADDR_W'(CH_BASE + c*CH_STRIDE + 8));
    end else begin : g_off
      assign hitConst[c] = 1'b0;
      assign hitCount[c] = 1'b0;
      assign hitCtrl[c]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runReg <= '0;
      preCnt <= '0;
    end else begin
      if (hitRun && wr) runReg <= wdata[MAX_CH-1:0] & CH_MASK;
      preCnt <= anyRun ? preCnt + 1'b1 : '0;
    end
  end

  for (genvar k = 0; k < NUM_DIV; k++) begin : g_tick
    assign strb.tick[k] = anyRun && (&preCnt[2*k+1:0]);
  end

  assign strb.wrConst = hitConst & {MAX_CH{wr}};
  assign strb.wrCount = hitCount & {MAX_CH{wr}};
  assign strb.wrCtrl  = hitCtrl  & {MAX_CH{wr}};
  assign strb.run     = runReg;
  assign strb.wdata   = wdata;

  always_comb begin
    rdata = '0;
    if (hitRun) rdata = DATA_W'(runReg);
    for (int c = 0; c < NUM_CH; c++) begin
      if (hitConst[c]) rdata = constVals[c*DATA_W +: DATA_W];
      if (hitCount[c]) rdata = cntVals[c*DATA_W +: DATA_W];
      if (hitCtrl[c])  rdata = DATA_W'(ctrlVals[c*CTRL_W +: CTRL_W]);
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  tmr_strb_t                strb,
  output logic [NUM_CH*DATA_W-1:0] constVals,
  output logic [NUM_CH*DATA_W-1:0] cntVals,
  output logic [NUM_CH*CTRL_W-1:0] ctrlVals,
  output logic [NUM_CH-1:0]        irq
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] cst, cnt;
    logic [2:0]        psc;
    logic              ie, flag, irqR;
    logic              tickSel, dec, under, flagNext, ieNext;

    always_comb begin
      case (psc)
        3'd0:    tickSel = strb.tick[0];
        3'd1:    tickSel = strb.tick[1];
        3'd2:    tickSel = strb.tick[2];
        3'd3:    tickSel = strb.tick[3];
        default: tickSel = strb.tick[4];
      endcase
    end

    assign dec      = strb.run[c] && tickSel;
    assign under    = dec && (cnt == '0) && !strb.wrCount[c];
    assign flagNext = (flag && !(strb.wrCtrl[c] && !strb.wdata[8])) || under;
    assign ieNext   = strb.wrCtrl[c] ? strb.wdata[5] : ie;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cst  <= '1;
        cnt  <= '1;
        psc  <= '0;
        ie   <= 1'b0;
        flag <= 1'b0;
        irqR <= 1'b0;
      end else begin
        if (strb.wrConst[c]) cst <= strb.wdata;
        if (strb.wrCount[c])  cnt <= strb.wdata;
        else if (under)       cnt <= cst;
        else if (dec)         cnt <= cnt - 1'b1;
        if (strb.wrCtrl[c])   psc <= strb.wdata[2:0];
        ie   <= ieNext;
        flag <= flagNext;
        irqR <= flagNext && ieNext;
      end
    end

    assign constVals[c*DATA_W +: DATA_W] = cst;
    assign cntVals[c*DATA_W +: DATA_W]   = cnt;
    assign ctrlVals[c*CTRL_W +: CTRL_W]  = {7'b0, flag, 2'b0, ie, 2'b0, psc};
    assign irq[c] = irqR;
  end
endmodule

// File: rtl/mc_timer.sv
module mc_timer
  import tmr_pkg::*;
#(
  parameter int NUM_CH    = 3,
  parameter int ADDR_W    = 8,
  parameter int START_OFS = 4,
  parameter int CH_BASE   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic [NUM_CH-1:0] irq
);
  tmr_strb_t                strb;
  logic [NUM_CH*DATA_W-1:0] constVals, cntVals;
  logic [NUM_CH*CTRL_W-1:0] ctrlVals;

  tmr_ctrl #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .START_OFS(START_OFS), .CH_BASE(CH_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
    .constVals(constVals), .cntVals(cntVals), .ctrlVals(ctrlVals),
    .strb(strb), .rdata(rdata)
  );

  tmr_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .constVals(constVals), .cntVals(cntVals), .ctrlVals(ctrlVals), .irq(irq)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 3
) (
  input logic                     clk,
  input logic                     rstN,
  input tmr_strb_t                strb,
  input logic [NUM_CH*DATA_W-1:0] constVals,
  input logic [NUM_CH*DATA_W-1:0] cntVals,
  input logic [NUM_CH*CTRL_W-1:0] ctrlVals,
  input logic [NUM_CH-1:0]        irq
);
  // R4
  presc_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tick != '0) |-> (strb.run != '0));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_a
    // R8
    irq_level_chk: assert property (@(posedge clk) disable iff (!rstN)
      irq[c] == (ctrlVals[c*CTRL_W+8] && ctrlVals[c*CTRL_W+5]));
    // R5
    reload_chk: assert property (@(posedge clk) disable iff (!rstN)
      $rose(ctrlVals[c*CTRL_W+8]) |->
        cntVals[c*DATA_W +: DATA_W] == $past(constVals[c*DATA_W +: DATA_W]));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!strb.run[c] && !strb.wrCount[c]) |=> $stable(cntVals[c*DATA_W +: DATA_W]));
    // R9
    cnt_write_chk: assert property (@(posedge clk) disable iff (!rstN)
      strb.wrCount[c] |=> cntVals[c*DATA_W +: DATA_W] == $past(strb.wdata));
  end
endmodule

bind mc_timer tmr_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb), .constVals(constVals),
  .cntVals(cntVals), .ctrlVals(ctrlVals), .irq(irq)
);

// File: tb/sim_mc_timer.sv
module sim_mc_timer;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NCH-1:0] irq;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_timer #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rstN(rstN), .sel(sel), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  // Register map: run 4; ch n: reload 8+12n, count 12+12n, control 16+12n
  localparam int NV = 14;
  localparam logic        V_WR  [NV] = '{0,0,0,0,1,0,0,1,0,1,0,1,1,0};
  localparam logic [7:0]  V_AD  [NV] = '{4,8,12,16,20,20,8,16,16,4,4,4,16,28};
  localparam logic [31:0] V_DAT [NV] = '{0,0,0,0,32'h12345678,0,0,32'hFFFFFFFF,0,
                                         32'hFF,0,0,0,0};
  localparam logic [31:0] V_EXP [NV] = '{0,32'hFFFFFFFF,32'hFFFFFFFF,0,0,32'h12345678,
                                         32'hFFFFFFFF,0,32'h27,0,32'h7,0,0,0};
  // R1 rows 0-3, R2 rows 5,6,10, R10 and R7 row 8, R2 row 13
  localparam int          V_REQ [NV] = '{1,1,1,1,2,2,2,2,10,2,2,2,2,2};

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic readCheck(input int req, input logic [7:0] a, input logic [31:0] exp,
                           input string what);
    logic [31:0] d;
    busRead(a, d);
    check(req, d, exp, what);
  endtask

  task automatic ticks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    check(1, 32'(irq), 0, "R1 irq after reset");

    for (int i = 0; i < NV; i++) begin
      if (V_WR[i]) busWrite(V_AD[i], V_DAT[i]);
      else readCheck(V_REQ[i], V_AD[i], V_EXP[i], $sformatf("vector %0d", i));
    end

    // R5 R8: /4, reload 2, count 2, ie on; underflow at edge 12
    busWrite(8, 2); busWrite(12, 2); busWrite(16, 32'h20);
    busWrite(4, 1);
    ticks(11);
    check(5, 32'(irq[0]), 0, "R8 irq before underflow");
    readCheck(5, 12, 0, "R5 count at zero before tick");
    ticks(1);
    check(8, 32'(irq[0]), 1, "R8 irq at underflow");
    readCheck(5, 12, 2, "R5 reload on underflow");
    readCheck(5, 16, 32'h120, "R5 flag set");
    busWrite(4, 0);

    // R7: writing 1 keeps flag, writing 0 clears
    busWrite(16, 32'h120);
    readCheck(7, 16, 32'h120, "R7 flag kept on write of 1");
    busWrite(16, 32'h020);
    readCheck(7, 16, 32'h020, "R7 flag cleared");
    check(7, 32'(irq[0]), 0, "R7 irq after clear");

    // R8: enable off masks irq
    busWrite(12, 0); busWrite(16, 0);
    busWrite(4, 1);
    ticks(4);
    readCheck(8, 16, 32'h100, "R8 flag set with ie off");
    check(8, 32'(irq[0]), 0, "R8 irq masked");
    busWrite(16, 32'h120);
    check(8, 32'(irq[0]), 1, "R8 irq on enabling");
    busWrite(4, 0); busWrite(16, 0);

    // R4: code 1 -> /16
    busWrite(8, 5); busWrite(12, 0); busWrite(16, 1);
    busWrite(4, 1);
    ticks(15);
    readCheck(4, 16, 32'h001, "R4 /16 no tick at edge 15");
    ticks(1);
    readCheck(4, 16, 32'h101, "R4 /16 tick at edge 16");
    readCheck(5, 12, 5, "R5 reload 5");
    busWrite(4, 0); busWrite(16, 0);

    // R4: reserved code 6 -> /1024
    busWrite(12, 0); busWrite(16, 6);
    busWrite(4, 1);
    ticks(1023);
    readCheck(4, 16, 32'h006, "R4 code 6 no tick at 1023");
    ticks(1);
    readCheck(4, 16, 32'h106, "R4 code 6 tick at 1024");
    busWrite(4, 0); busWrite(16, 0);

    // R6: one-shot with full reload value
    busWrite(8, 32'hFFFFFFFF); busWrite(12, 0);
    busWrite(4, 1);
    ticks(4);
    readCheck(6, 12, 32'hFFFFFFFF, "R6 full value reloaded");
    ticks(4);
    readCheck(6, 12, 32'hFFFFFFFE, "R6 decrement from full value");
    busWrite(4, 0); busWrite(16, 0);

    // R9: count write on a tick edge wins
    busWrite(12, 10);
    busWrite(4, 1);
    ticks(3);
    busWrite(12, 100);
    readCheck(9, 12, 100, "R9 write beats decrement");
    ticks(4);
    readCheck(9, 12, 99, "R9 counting resumes");
    busWrite(4, 0);

    // R3: only channel 1 runs
    busWrite(12, 50); busWrite(24, 50); busWrite(28, 0);
    busWrite(4, 2);
    ticks(8);
    readCheck(3, 24, 48, "R3 running channel decrements");
    readCheck(3, 12, 50, "R3 stopped channel holds");
    readCheck(3, 4, 2, "R3 run bits");
    busWrite(4, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule